// File: doc/BRIEF.md
# 24-bit Accumulator Processor Core

This block is a small multicycle processor for a 24-bit accumulator machine. It reads its program from an external byte-wide synchronous memory. Each instruction is three bytes long, and each byte takes one memory read. After fetch, the core decodes an 8-bit operation code, an index flag and a 15-bit address. It then runs a short micro-sequence that does one of the following:

- reads an operand word or byte,
- writes a register out to memory,
- changes the program counter,
- talks to a peripheral through a polled device port.

The core has these registers: an accumulator, an index register, a linkage register for subroutine return, a program counter and a two-bit condition code. Memory words are big-endian. The byte at the lowest address is the most significant, and a word is named by that address. The core has no halt instruction. A program ends on an unknown operation code. The core then raises a trap flag and stops all bus activity until the next reset.

Top module: `acc24_core`

## Requirements
- R1: During reset, no memory write, device strobe or trap is driven. After reset is released, the first three memory reads are at addresses 0, 1 and 2.
- R2: An instruction is three bytes read in increasing address order. The first byte is the operation code, bit 15 is the index flag, and bits 14..0 are the address field. The program counter advances by 3 per instruction.
- R3: Word loads and stores move three bytes, most significant byte at the lowest address. The opcodes are load accumulator 0x00, load index 0x04, store accumulator 0x0C, store index 0x10 and store linkage 0x14.
- R4: With the index flag clear, the target address is the address field. With it set, the target address is the address field plus the index register, modulo 2^15.
- R5: Add (0x18) and subtract (0x1C) combine the accumulator with a memory word and wrap modulo 2^24.
- R6: Compare (0x28) orders the accumulator against a memory word as signed two's complement numbers. Jump-if-less (0x38), jump-if-equal (0x30) and jump-if-greater (0x34) take the branch only on the matching result. Jump (0x3C) always branches.
- R7: Call (0x48) writes the address after the call into the linkage register and jumps to the target. Return (0x4C) jumps to the address held in the linkage register.
- R8: Byte load (0x50) replaces only the low byte of the accumulator. Byte store (0x54) writes only the accumulator's low byte to the single target byte.
- R9: Test-device (0xE0) presents the memory byte at the target address as the device code. It sets the condition code to "less" when the ready input is high and to "equal" when it is low.
- R10: Read-device (0xD8) pulses the read strobe for one cycle and loads the data input into the accumulator's low byte. Write-device (0xDC) pulses the write strobe for one cycle with the accumulator's low byte on the data output.
- R11: An unknown operation code sets the trap output. The trap stays set, the erroneous instruction has no effect, and no later memory or device access takes place.
- R12: Memory read, memory write, device read and device write are never active in the same cycle. The bytes of one store go to consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 15 | Byte address for memory read or write |
| mem_re | output | 1 | Memory read request; data returns on the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid one cycle after the request |
| dev_code | output | 8 | Code of the addressed device |
| dev_ready | input | 1 | Addressed device is ready |
| dev_rd | output | 1 | One-cycle device read strobe |
| dev_rdata | input | 8 | Byte from the device |
| dev_wr | output | 1 | One-cycle device write strobe |
| dev_wdata | output | 8 | Byte to the device |
| trap | output | 1 | Unknown opcode seen; core halted |

## Verification
The bench compares the accumulator against values near the signed limits, such as 0x7FFFFF against 0x800000. A core that compared without sign would take the opposite branch there. Add and subtract are driven across the 24-bit wrap, where a lost carry or stray bit would show up in the stored word. Indexed byte stores check that the neighbouring byte stays untouched, and byte loads check that the accumulator's upper bytes survive. Further cases cover:

- a call/return pair, where a wrong return address lands on the wrong instruction;
- a device that stays not-ready for many polls, so a read issued before ready would be caught;
- an unknown opcode placed in front of a store, whose write must never appear.

// File: rtl/acc24_pkg.sv
package acc24_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 24;
    localparam int ADDR_W     = 15;
    localparam int OPC_W      = 8;
    localparam int WORD_BYTES = WORD_W / BYTE_W;
    localparam int CNT_W      = $clog2(WORD_BYTES + 1);
    localparam int XBIT       = ADDR_W;
    localparam int OPC_LSB    = ADDR_W + 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [OPC_W-1:0]  opc_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    localparam opc_t OP_LDA  = 8'h00;
    localparam opc_t OP_LDX  = 8'h04;
    localparam opc_t OP_STA  = 8'h0C;
    localparam opc_t OP_STX  = 8'h10;
    localparam opc_t OP_STL  = 8'h14;
    localparam opc_t OP_ADD  = 8'h18;
    localparam opc_t OP_SUB  = 8'h1C;
    localparam opc_t OP_COMP = 8'h28;
    localparam opc_t OP_JEQ  = 8'h30;
    localparam opc_t OP_JGT  = 8'h34;
    localparam opc_t OP_JLT  = 8'h38;
    localparam opc_t OP_J    = 8'h3C;
    localparam opc_t OP_JSUB = 8'h48;
    localparam opc_t OP_RSUB = 8'h4C;
    localparam opc_t OP_LDCH = 8'h50;
    localparam opc_t OP_STCH = 8'h54;
    localparam opc_t OP_RD   = 8'hD8;
    localparam opc_t OP_WD   = 8'hDC;
    localparam opc_t OP_TD   = 8'hE0;

    typedef enum logic [1:0] {CC_EQ = 2'b00, CC_LT = 2'b01, CC_GT = 2'b10} cc_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_LOAD, ST_STORE, ST_EXEC, ST_IO, ST_HALT
    } state_e;

    typedef enum logic [3:0] {
        EX_NONE, EX_LDA, EX_LDX, EX_ADD, EX_SUB, EX_COMP, EX_LDCH, EX_TD, EX_RD, EX_WD
    } exec_e;

    typedef enum logic [2:0] {JC_NEVER, JC_ALWAYS, JC_EQ, JC_GT, JC_LT} jcond_e;

    typedef enum logic [1:0] {SRC_A, SRC_X, SRC_L, SRC_ACH} ssrc_e;

    typedef struct packed {
        logic   legal;
        logic   load;
        logic   store;
        logic   jump;
        logic   link;
        logic   ret;
        jcond_e jc;
        exec_e  ex;
        ssrc_e  src;
        cnt_t   nbytes;
    } dec_t;

    typedef struct packed {
        state_e st;
        cnt_t   cnt;
        addr_t  pc;
        addr_t  ta;
        word_t  ir;
        word_t  mdr;
        word_t  sdr;
        word_t  a;
        word_t  x;
        word_t  l;
        cc_e    cc;
        byte_t  devc;
        dec_t   dec;
        logic   trap;
    } core_t;

endpackage

// File: rtl/acc24_decode.sv
module acc24_decode
    import acc24_pkg::*;
(
    input  opc_t opcode,
    output dec_t dec
);
    localparam cnt_t NB_WORD = cnt_t'(WORD_BYTES);
    localparam cnt_t NB_BYTE = cnt_t'(1);

    always_comb begin
        dec        = '0;
        dec.legal  = 1'b1;
        dec.jc     = JC_NEVER;
        dec.ex     = EX_NONE;
        dec.src    = SRC_A;
        dec.nbytes = NB_WORD;
        unique case (opcode)
            OP_LDA:  begin dec.load = 1'b1; dec.ex = EX_LDA;  end
            OP_LDX:  begin dec.load = 1'b1; dec.ex = EX_LDX;  end
            OP_ADD:  begin dec.load = 1'b1; dec.ex = EX_ADD;  end
            OP_SUB:  begin dec.load = 1'b1; dec.ex = EX_SUB;  end
            OP_COMP: begin dec.load = 1'b1; dec.ex = EX_COMP; end
            OP_LDCH: begin dec.load = 1'b1; dec.ex = EX_LDCH; dec.nbytes = NB_BYTE; end
            OP_TD:   begin dec.load = 1'b1; dec.ex = EX_TD;   dec.nbytes = NB_BYTE; end
            OP_RD:   begin dec.load = 1'b1; dec.ex = EX_RD;   dec.nbytes = NB_BYTE; end
            OP_WD:   begin dec.load = 1'b1; dec.ex = EX_WD;   dec.nbytes = NB_BYTE; end
            OP_STA:  begin dec.store = 1'b1; dec.src = SRC_A; end
            OP_STX:  begin dec.store = 1'b1; dec.src = SRC_X; end
            OP_STL:  begin dec.store = 1'b1; dec.src = SRC_L; end
            OP_STCH: begin dec.store = 1'b1; dec.src = SRC_ACH; dec.nbytes = NB_BYTE; end
            OP_J:    begin dec.jump = 1'b1; dec.jc = JC_ALWAYS; end
            OP_JEQ:  begin dec.jump = 1'b1; dec.jc = JC_EQ; end
            OP_JGT:  begin dec.jump = 1'b1; dec.jc = JC_GT; end
            OP_JLT:  begin dec.jump = 1'b1; dec.jc = JC_LT; end
            OP_JSUB: begin dec.jump = 1'b1; dec.jc = JC_ALWAYS; dec.link = 1'b1; end
            OP_RSUB: begin dec.jump = 1'b1; dec.ret = 1'b1; end
            default: dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc24_tagen.sv
module acc24_tagen
    import acc24_pkg::*;
#(
    parameter bit INDEXED = 1'b1
) (
    input  addr_t field,
    input  logic  xflag,
    input  addr_t xval,
    output addr_t ta
);
    generate
        if (INDEXED) begin : g_indexed
            // sum truncated to the address width: wraps modulo 2^ADDR_W
            assign ta = xflag ? addr_t'(field + xval) : field;
        end else begin : g_direct
            logic unused_idx;
            assign unused_idx = xflag ^ (^xval);
            assign ta = field;
        end
    endgenerate
endmodule

// File: rtl/acc24_alu.sv
module acc24_alu
    import acc24_pkg::*;
(
    input  word_t opa,
    input  word_t opb,
    input  logic  sub,
    output word_t res,
    output cc_e   cc
);
    always_comb begin
        res = sub ? word_t'(opa - opb) : word_t'(opa + opb);
        if ($signed(opa) < $signed(opb)) begin
            cc = CC_LT;
        end else if (opa == opb) begin
            cc = CC_EQ;
        end else begin
            cc = CC_GT;
        end
    end
endmodule

// File: rtl/acc24_core.sv
module acc24_core
    import acc24_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] dev_code,
    input  logic              dev_ready,
    output logic              dev_rd,
    input  logic [BYTE_W-1:0] dev_rdata,
    output logic              dev_wr,
    output logic [BYTE_W-1:0] dev_wdata,
    output logic              trap
);
    localparam cnt_t  LAST_INS = cnt_t'(WORD_BYTES);
    localparam addr_t INS_LEN  = addr_t'(WORD_BYTES);
    localparam int    LO_W     = WORD_W - BYTE_W;

    core_t q, n;

    // instruction fields
    opc_t  ir_opc;
    logic  ir_x;
    addr_t ir_field;
    assign ir_opc   = q.ir[WORD_W-1:OPC_LSB];
    assign ir_x     = q.ir[XBIT];
    assign ir_field = q.ir[ADDR_W-1:0];

    dec_t  dec_w;
    addr_t ta_w;
    word_t alu_res;
    cc_e   alu_cc;
    logic  alu_sub;

    assign alu_sub = (q.dec.ex == EX_SUB) || (q.dec.ex == EX_COMP);

    acc24_decode u_dec (
        .opcode (ir_opc),
        .dec    (dec_w)
    );

    acc24_tagen #(.INDEXED(1'b1)) u_ta (
        .field (ir_field),
        .xflag (ir_x),
        .xval  (q.x[ADDR_W-1:0]),
        .ta    (ta_w)
    );

    acc24_alu u_alu (
        .opa (q.a),
        .opb (q.mdr),
        .sub (alu_sub),
        .res (alu_res),
        .cc  (alu_cc)
    );

    logic take;
    always_comb begin
        unique case (dec_w.jc)
            JC_ALWAYS: take = 1'b1;
            JC_EQ:     take = (q.cc == CC_EQ);
            JC_GT:     take = (q.cc == CC_GT);
            JC_LT:     take = (q.cc == CC_LT);
            default:   take = 1'b0;
        endcase
    end

    word_t store_src;
    always_comb begin
        unique case (dec_w.src)
            SRC_X:   store_src = q.x;
            SRC_L:   store_src = q.l;
            SRC_ACH: store_src = {q.a[BYTE_W-1:0], {LO_W{1'b0}}};
            default: store_src = q.a;
        endcase
    end

    always_comb begin
        n         = q;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.pc;
        mem_wdata = q.sdr[WORD_W-1:LO_W];
        dev_rd    = 1'b0;
        dev_wr    = 1'b0;

        unique case (q.st)
            ST_FETCH: begin
                if (q.cnt < LAST_INS) begin
                    mem_re   = 1'b1;
                    mem_addr = addr_t'(q.pc + addr_t'(q.cnt));
                end
                if (q.cnt != '0) begin
                    n.ir = {q.ir[LO_W-1:0], mem_rdata};
                end
                if (q.cnt == LAST_INS) begin
                    n.st  = ST_DECODE;
                    n.cnt = '0;
                    n.pc  = addr_t'(q.pc + INS_LEN);
                end else begin
                    n.cnt = cnt_t'(q.cnt + 1'b1);
                end
            end

            ST_DECODE: begin
                n.dec = dec_w;
                n.ta  = ta_w;
                n.mdr = '0;
                n.cnt = '0;
                if (!dec_w.legal) begin
                    n.st   = ST_HALT;
                    n.trap = 1'b1;
                end else if (dec_w.load) begin
                    n.st = ST_LOAD;
                end else if (dec_w.store) begin
                    n.st  = ST_STORE;
                    n.sdr = store_src;
                end else begin
                    if (dec_w.ret) begin
                        n.pc = q.l[ADDR_W-1:0];
                    end else if (take) begin
                        n.pc = ta_w;
                    end
                    if (dec_w.link) begin
                        n.l = word_t'(q.pc);
                    end
                    n.st = ST_FETCH;
                end
            end

            ST_LOAD: begin
                if (q.cnt < q.dec.nbytes) begin
                    mem_re   = 1'b1;
                    mem_addr = addr_t'(q.ta + addr_t'(q.cnt));
                end
                if (q.cnt != '0) begin
                    n.mdr = {q.mdr[LO_W-1:0], mem_rdata};
                end
                if (q.cnt == q.dec.nbytes) begin
                    n.st  = ST_EXEC;
                    n.cnt = '0;
                end else begin
                    n.cnt = cnt_t'(q.cnt + 1'b1);
                end
            end

            ST_STORE: begin
                mem_we   = 1'b1;
                mem_addr = addr_t'(q.ta + addr_t'(q.cnt));
                n.sdr    = {q.sdr[LO_W-1:0], {BYTE_W{1'b0}}};
                if (q.cnt == cnt_t'(q.dec.nbytes - 1'b1)) begin
                    n.st  = ST_FETCH;
                    n.cnt = '0;
                end else begin
                    n.cnt = cnt_t'(q.cnt + 1'b1);
                end
            end

            ST_EXEC: begin
                n.st = ST_FETCH;
                unique case (q.dec.ex)
                    EX_LDA:  n.a = q.mdr;
                    EX_LDX:  n.x = q.mdr;
                    EX_ADD:  n.a = alu_res;
                    EX_SUB:  n.a = alu_res;
                    EX_COMP: n.cc = alu_cc;
                    EX_LDCH: n.a = {q.a[WORD_W-1:BYTE_W], q.mdr[BYTE_W-1:0]};
                    EX_TD, EX_RD, EX_WD: begin
                        n.devc = q.mdr[BYTE_W-1:0];
                        n.st   = ST_IO;
                    end
                    default: n.st = ST_FETCH;
                endcase
            end

            ST_IO: begin
                n.st = ST_FETCH;
                unique case (q.dec.ex)
                    EX_TD: n.cc = dev_ready ? CC_LT : CC_EQ;
                    EX_RD: begin
                        dev_rd = 1'b1;
                        n.a    = {q.a[WORD_W-1:BYTE_W], dev_rdata};
                    end
                    EX_WD: dev_wr = 1'b1;
                    default: n.st = ST_FETCH;
                endcase
            end

            default: n.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_FETCH;
            q.pc  <= RESET_PC;
            q.cc  <= CC_EQ;
            q.dec <= '0;
        end else begin
            q <= n;
        end
    end

    assign dev_code  = q.devc;
    assign dev_wdata = q.a[BYTE_W-1:0];
    assign trap      = q.trap;

endmodule

// File: rtl/acc24_core_chk.sv
module acc24_core_chk
    import acc24_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic        mem_re,
    input logic        mem_we,
    input logic        dev_rd,
    input logic        dev_wr,
    input logic        trap
);
    // R12: only one bus or device action per cycle
    p_bus_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_re, mem_we, dev_rd, dev_wr}));

    // R12: successive store bytes walk upward through memory
    p_store_seq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R11: trap is sticky
    p_trap_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> trap);

    // R11: a trapped core stays off both buses
    p_trap_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !(mem_re || mem_we || dev_rd || dev_wr));

    // R10: device strobes last a single cycle
    p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd |=> !dev_rd);

    p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr |=> !dev_wr);
endmodule

bind acc24_core acc24_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_re   (mem_re),
    .mem_we   (mem_we),
    .dev_rd   (dev_rd),
    .dev_wr   (dev_wr),
    .trap     (trap)
);

// File: tb/acc24_core_tb.sv
module acc24_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_SIZE   = 4096;
    localparam int RUN_LIMIT  = 3000;

    localparam logic [7:0] I_LDA = 8'h00, I_LDX = 8'h04, I_STA = 8'h0C, I_STX = 8'h10,
                           I_STL = 8'h14, I_ADD = 8'h18, I_SUB = 8'h1C, I_COMP = 8'h28,
                           I_JEQ = 8'h30, I_JGT = 8'h34, I_JLT = 8'h38, I_J = 8'h3C,
                           I_JSUB = 8'h48, I_RSUB = 8'h4C, I_LDCH = 8'h50, I_STCH = 8'h54,
                           I_RD = 8'hD8, I_WD = 8'hDC, I_TD = 8'hE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  dev_code;
    logic        dev_ready;
    logic        dev_rd, dev_wr;
    logic [7:0]  dev_rdata = 8'h00;
    logic [7:0]  dev_wdata;
    logic        trap;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc24_core u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_code(dev_code),
        .dev_ready(dev_ready), .dev_rd(dev_rd), .dev_rdata(dev_rdata), .dev_wr(dev_wr),
        .dev_wdata(dev_wdata), .trap(trap)
    );

    logic [7:0] img [0:MEM_SIZE-1];
    logic [7:0] mem [0:MEM_SIZE-1];
    logic       load_req = 1'b0;

    always @(posedge clk) begin
        if (load_req) begin
            for (int i = 0; i < MEM_SIZE; i++) mem[i] <= img[i];
        end else begin
            if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
            if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
        end
    end

    int ready_at = 0;
    int cyc, rd_cnt, wr_cnt, rd_cyc, rlog_n;
    logic [7:0] rd_code, wr_code, wr_data;
    logic [14:0] rlog [0:2];
    int quiet_viol = 0, excl_viol = 0;
    assign dev_ready = (cyc >= ready_at);

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; rd_cnt = 0; wr_cnt = 0; rd_cyc = 0; rlog_n = 0;
        end else begin
            cyc++;
            if (mem_re && rlog_n < 3) begin rlog[rlog_n] = mem_addr; rlog_n++; end
            if (dev_rd) begin rd_cnt++; rd_code = dev_code; rd_cyc = cyc; end
            if (dev_wr) begin wr_cnt++; wr_code = dev_code; wr_data = dev_wdata; end
            if (trap && (mem_re || mem_we || dev_rd || dev_wr)) quiet_viol++;
            if ((32'(mem_re) + 32'(mem_we) + 32'(dev_rd) + 32'(dev_wr)) > 1) excl_viol++;
        end
    end

    int nchk = 0, nerr = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] mk(input logic [7:0] op, input logic x, input int a);
        return {op, x, a[14:0]};
    endfunction

    task automatic clr_img();
        for (int i = 0; i < MEM_SIZE; i++) img[i] = 8'h00;
    endtask

    task automatic put(input int a, input logic [23:0] w);
        img[a] = w[23:16]; img[a+1] = w[15:8]; img[a+2] = w[7:0];
    endtask

    function automatic logic [23:0] get(input int a);
        return {mem[a], mem[a+1], mem[a+2]};
    endfunction

    function automatic logic [23:0] f_arith(input logic sub, input logic [23:0] a, input logic [23:0] b);
        return sub ? 24'(a - b) : 24'(a + b);
    endfunction

    function automatic logic [23:0] f_cmp(input logic [23:0] a, input logic [23:0] b);
        if ($signed(a) < $signed(b)) return 24'd1;
        if (a == b) return 24'd2;
        return 24'd3;
    endfunction

    task automatic run_prog();
        int n;
        rst_n = 1'b0;
        @(negedge clk) load_req = 1'b1;
        @(negedge clk) load_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!trap && n < RUN_LIMIT) begin @(negedge clk); n++; end
        if (!trap) begin
            nchk++; nerr++;
            $display("FAIL run watchdog: actual %0d expected trap", n);
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic t_arith(input logic sub, input logic [23:0] va, input logic [23:0] vb);
        clr_img();
        put(0, mk(I_LDA, 0, 'h100));
        put(3, mk(sub ? I_SUB : I_ADD, 0, 'h103));
        put(6, mk(I_STA, 0, 'h106));
        put(9, mk(I_LDX, 0, 'h103));
        put(12, mk(I_STX, 0, 'h109));
        img[15] = 8'hFF;
        put('h100, va); put('h103, vb);
        run_prog();
        chk("R5 R3 arith result", 32'(get('h106)), 32'(f_arith(sub, va, vb)));
        chk("R3 index load/store", 32'(get('h109)), 32'(vb));
    endtask

    task automatic t_cmp(input logic [23:0] va, input logic [23:0] vb);
        clr_img();
        put(0, mk(I_LDA, 0, 'h100));
        put(3, mk(I_COMP, 0, 'h103));
        put(6, mk(I_JLT, 0, 18));
        put(9, mk(I_JEQ, 0, 24));
        put(12, mk(I_JGT, 0, 30));
        img[15] = 8'hFF;
        put(18, mk(I_LDA, 0, 'h110)); put(21, mk(I_J, 0, 36));
        put(24, mk(I_LDA, 0, 'h113)); put(27, mk(I_J, 0, 36));
        put(30, mk(I_LDA, 0, 'h116)); put(33, mk(I_J, 0, 36));
        put(36, mk(I_STA, 0, 'h106));
        img[39] = 8'hFF;
        put('h100, va); put('h103, vb);
        put('h110, 24'd1); put('h113, 24'd2); put('h116, 24'd3);
        run_prog();
        chk("R6 compare/branch", 32'(get('h106)), 32'(f_cmp(va, vb)));
    endtask

    task automatic t_index(input logic [5:0] xv, input logic [23:0] va, input logic [7:0] rb);
        clr_img();
        put(0, mk(I_LDX, 0, 'h100));
        put(3, mk(I_LDA, 0, 'h103));
        put(6, mk(I_STCH, 1, 'h200));
        put(9, mk(I_LDCH, 1, 'h300));
        put(12, mk(I_STA, 0, 'h106));
        img[15] = 8'hFF;
        put('h100, 24'(xv)); put('h103, va);
        img['h300 + int'(xv)] = rb;
        run_prog();
        chk("R4 R8 indexed byte store", 32'(mem['h200 + int'(xv)]), 32'(va[7:0]));
        chk("R8 neighbour byte untouched", 32'(mem['h201 + int'(xv)]), 32'h0);
        chk("R8 byte load keeps upper", 32'(get('h106)), 32'({va[23:8], rb}));
    endtask

    initial begin
        logic [23:0] ra, rb;
        int r;
        r = int'($urandom(32'd20240611));

        // R1: reset behaviour
        clr_img(); img[0] = 8'hFF;
        rst_n = 1'b0;
        @(negedge clk) load_req = 1'b1;
        @(negedge clk) load_req = 1'b0;
        @(negedge clk);
        chk("R1 no write in reset", 32'({mem_we, dev_rd, dev_wr}), 32'h0);
        chk("R1 trap low in reset", 32'(trap), 32'h0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R1 R2 first fetch addr0", 32'(rlog[0]), 32'h0);
        chk("R1 R2 first fetch addr1", 32'(rlog[1]), 32'h1);
        chk("R1 R2 first fetch addr2", 32'(rlog[2]), 32'h2);
        chk("R11 trap on unknown opcode", 32'(trap), 32'h1);

        // R5: directed wrap cases, then random
        t_arith(1'b0, 24'hFFFFFF, 24'h000001);
        t_arith(1'b1, 24'h000000, 24'h000001);
        t_arith(1'b0, 24'h7FFFFF, 24'h000001);
        for (int k = 0; k < 20; k++) t_arith(1'($urandom), 24'($urandom), 24'($urandom));

        // R6: signed limits, equality, random
        t_cmp(24'h7FFFFF, 24'h800000);
        t_cmp(24'h800000, 24'h7FFFFF);
        t_cmp(24'h123456, 24'h123456);
        t_cmp(24'hFFFFFF, 24'h000000);
        for (int k = 0; k < 20; k++) begin
            ra = 24'($urandom);
            rb = ($urandom % 4 == 0) ? ra : 24'($urandom);
            t_cmp(ra, rb);
        end

        // R4 R8: indexed byte paths
        t_index(6'd0, 24'hABCDEF, 8'h5A);
        for (int k = 0; k < 8; k++) t_index(6'($urandom), 24'($urandom), 8'($urandom));

        // R7: call and return
        clr_img();
        put(0, mk(I_JSUB, 0, 'h30));
        put(3, mk(I_STA, 0, 'h106));
        put(6, mk(I_STL, 0, 'h109));
        img[9] = 8'hFF;
        put('h30, mk(I_LDA, 0, 'h100));
        put('h33, mk(I_STL, 0, 'h10C));
        put('h36, {I_RSUB, 16'h0000});
        put('h100, 24'h31415A);
        run_prog();
        chk("R7 linkage holds return address", 32'(get('h10C)), 32'h3);
        chk("R7 return resumes after call", 32'(get('h106)), 32'h31415A);
        chk("R7 R2 linkage after return", 32'(get('h109)), 32'h3);

        // R9 R10: polled device transfer
        for (int k = 0; k < 3; k++) begin
            ready_at = (k == 0) ? 0 : 40 + 70 * k;
            dev_rdata = 8'($urandom);
            ra = 24'($urandom);
            clr_img();
            put(0, mk(I_LDA, 0, 'h100));
            put(3, mk(I_TD, 0, 'h120));
            put(6, mk(I_JEQ, 0, 3));
            put(9, mk(I_RD, 0, 'h120));
            put(12, mk(I_WD, 0, 'h121));
            put(15, mk(I_STA, 0, 'h106));
            img[18] = 8'hFF;
            put('h100, ra);
            img['h120] = 8'hF3; img['h121] = 8'h05;
            run_prog();
            chk("R10 one read strobe", 32'(rd_cnt), 32'h1);
            chk("R9 read device code", 32'(rd_code), 32'hF3);
            chk("R9 read waits for ready", 32'(rd_cyc >= ready_at), 32'h1);
            chk("R10 one write strobe", 32'(wr_cnt), 32'h1);
            chk("R10 write code", 32'(wr_code), 32'h05);
            chk("R10 write data", 32'(wr_data), 32'(dev_rdata));
            chk("R10 read keeps upper bytes", 32'(get('h106)), 32'({ra[23:8], dev_rdata}));
        end
        ready_at = 0;

        // R11: unknown opcode blocks the following store
        clr_img();
        put(0, mk(I_LDA, 0, 'h100));
        put(3, {8'h44, 16'h0106});
        put(6, mk(I_STA, 0, 'h106));
        img[9] = 8'hFF;
        put('h100, 24'h777777);
        run_prog();
        chk("R11 trap set", 32'(trap), 32'h1);
        chk("R11 no store after unknown opcode", 32'(get('h106)), 32'h0);

        chk("R11 no activity while trapped", 32'(quiet_viol), 32'h0);
        chk("R12 strobes exclusive", 32'(excl_viol), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL global watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule